// File: doc/BRIEF.md
# Weighted-Round Queue Scheduler with Strict-Priority Head

This block chooses which of the output queues of one port sends the next packet. Each queue has a four-bit level. Levels 0 to 8 give weighted service. Level 9 marks the queue as a strict-priority queue. A weighted level expands into an eight-bit participation pattern. A three-bit round counter selects one bit of that pattern, so a queue at level 8 takes part in all eight rounds and a queue at level 1 takes part in only one.

Strict-priority queues are served before any weighted queue. Among them, the lowest-numbered non-empty one wins. Weighted queues are served round-robin within the current round, starting after the last weighted queue that was granted. When no queue can go in the current round, the scheduler moves to the nearest later round in which some queue can go.

The grant is computed combinationally from the current inputs and state. The state advances only when the consumer accepts a weighted grant. Levels may change at any time, and the next decision uses the new values. A configuration flag reports two problems: any level of 10 or more, and any strict queue placed after a weighted queue.

Top module: `wrr_static_sched`

## Requirements
- R1: When no queue is both non-empty and eligible, `gnt_valid` is 0.
- R2: Levels map to participation patterns as follows, where bit r is round r: 0→0x00, 1→0x01, 2→0x11, 3→0x49, 4→0x55, 5→0x57, 6→0x77, 7→0x7F, 8→0xFF. A weighted queue is eligible in round r only if it is non-empty and bit r of its pattern is set.
- R3: A queue at level 0 is never granted.
- R4: Level 9 marks a strict queue. If any strict queue is non-empty, the grant goes to the lowest-numbered non-empty strict queue and `gnt_static` is 1.
- R5: An accepted strict grant leaves the round counter and the round-robin pointer unchanged.
- R6: Within a round, weighted queues are scanned in rising index order. The scan starts after the last accepted weighted queue and wraps around.
- R7: If no queue is eligible in the current round, the grant comes from the nearest later round (mod 8) that has an eligible queue. After an accepted weighted grant, the round becomes that grant's round plus 1.
- R8: A level of 10 to 15 raises `cfg_err`, and the queue is treated as weighted with pattern 0xFF.
- R9: `cfg_err` is raised when a level-9 queue has a higher index than some queue whose level is not 9.
- R10: Level changes take effect on the very next grant decision, with no reset or idle period needed.
- R11: Without `grant_ack`, and with stable inputs, the grant does not change.
- R12: After reset the round is 0 and the pointer sits on the last queue, so the first weighted grant is the lowest eligible queue in round 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_nonempty | input | NQ | Per-queue has-packet flags |
| q_level | input | 4*NQ | Per-queue level, queue i in bits [4i+3:4i] |
| grant_ack | input | 1 | Consumer accepts the current grant |
| gnt_valid | output | 1 | A grant is offered |
| gnt_queue | output | QW | Index of the granted queue |
| gnt_static | output | 1 | The grant went to a strict-priority queue |
| cfg_err | output | 1 | Level out of range, or strict queue after a weighted one |

## Verification
The bench builds the block with NQ = 4. With four queues, the mix of strict, weighted, zero-level and out-of-range levels stays small, yet every round and every wrap of the pointer is reached within a few thousand cycles. A pseudo-random sweep changes levels, occupancy and acceptance on every cycle. Each cycle is compared against an arithmetic reference of the round and pointer rules. Directed cases cover the reset grant, the share between a level-1 and a level-8 queue, and both causes of the configuration error.

// File: rtl/wrr_static_sched.sv
module wrr_static_sched #(
  parameter int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NQ-1:0]   q_nonempty,
  input  logic [4*NQ-1:0] q_level,
  input  logic            grant_ack,
  output logic            gnt_valid,
  output logic [QW-1:0]   gnt_queue,
  output logic            gnt_static,
  output logic            cfg_err
);

  function automatic logic [7:0] lvl_pattern(input logic [3:0] l);
    case (l)
      4'd0: return 8'h00;
      4'd1: return 8'h01;
      4'd2: return 8'h11;
      4'd3: return 8'h49;
      4'd4: return 8'h55;
      4'd5: return 8'h57;
      4'd6: return 8'h77;
      4'd7: return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

  logic [2:0]    rnd;
  logic [QW-1:0] lastq;
  logic [NQ-1:0] is_static;
  logic [7:0]    pat [NQ];
  logic          st_hit, w_hit, err_c;
  logic [QW-1:0] st_idx, w_idx;
  logic [2:0]    w_rnd;

  always_comb begin
    err_c = 1'b0;
    for (int i = 0; i < NQ; i++) begin
      is_static[i] = (q_level[4*i +: 4] == 4'd9);
      pat[i] = lvl_pattern(q_level[4*i +: 4]);
      if (q_level[4*i +: 4] > 4'd9) err_c = 1'b1;
    end
    for (int i = 1; i < NQ; i++)
      for (int k = 0; k < i; k++)
        if (is_static[i] && !is_static[k]) err_c = 1'b1;
  end

  always_comb begin
    st_hit = 1'b0;
    st_idx = '0;
    for (int i = NQ - 1; i >= 0; i--)
      if (is_static[i] && q_nonempty[i]) begin
        st_hit = 1'b1;
        st_idx = QW'(i);
      end
  end

  always_comb begin
    w_hit = 1'b0;
    w_idx = '0;
    w_rnd = '0;
    for (int k = 0; k < 8; k++) begin
      for (int j = 1; j <= NQ; j++) begin
        int q;
        logic [2:0] rr;
        q = int'(lastq) + j;
        if (q >= NQ) q = q - NQ;
        rr = rnd + 3'(k);
        if (!w_hit && q_nonempty[q] && !is_static[q] && pat[q][rr]) begin
          w_hit = 1'b1;
          w_idx = QW'(q);
          w_rnd = rr;
        end
      end
    end
  end

  assign gnt_valid  = st_hit | w_hit;
  assign gnt_static = st_hit;
  assign gnt_queue  = st_hit ? st_idx : w_idx;
  assign cfg_err    = err_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rnd   <= '0;
      lastq <= QW'(NQ - 1);
    end else if (grant_ack && w_hit && !st_hit) begin
      rnd   <= w_rnd + 3'd1;
      lastq <= w_idx;
    end
  end

  // R1
  no_idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_nonempty == '0) |-> !gnt_valid);

  // R3
  zero_level_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (q_level[4*gnt_queue +: 4] != 4'd0));

  // R4
  static_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !gnt_static) |-> ((is_static & q_nonempty) == '0));

  // R5
  static_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_ack && gnt_static) |=> ($stable(rnd) && $stable(lastq)));

  // R11
  hold_without_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !grant_ack) ##1 ($stable(q_nonempty) && $stable(q_level))
      |-> ($stable(gnt_queue) && gnt_valid));

endmodule

// File: tb/wrr_static_sched_tb.sv
module wrr_static_sched_tb;
  localparam int NQ = 4;
  localparam int QW = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NQ-1:0]   q_nonempty;
  logic [4*NQ-1:0] q_level;
  logic            grant_ack;
  logic            gnt_valid, gnt_static, cfg_err;
  logic [QW-1:0]   gnt_queue;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  wrr_static_sched #(.NQ(NQ)) u_dut (
    .clk(clk), .rst_n(rst_n), .q_nonempty(q_nonempty), .q_level(q_level),
    .grant_ack(grant_ack), .gnt_valid(gnt_valid), .gnt_queue(gnt_queue),
    .gnt_static(gnt_static), .cfg_err(cfg_err));

  always #4 clk = ~clk;

  int m_rnd, m_last;
  logic e_valid, e_static, e_err;
  int e_q, e_rnd;

  function automatic int ref_pat(int l);
    case (l)
      0: return 'h00; 1: return 'h01; 2: return 'h11; 3: return 'h49;
      4: return 'h55; 5: return 'h57; 6: return 'h77; 7: return 'h7F;
      default: return 'hFF;
    endcase
  endfunction

  task automatic model();
    int lv [NQ];
    bit seen_w;
    for (int i = 0; i < NQ; i++) lv[i] = int'(q_level[4*i +: 4]);
    e_err = 1'b0; seen_w = 0;
    for (int i = 0; i < NQ; i++) begin
      if (lv[i] > 9) e_err = 1'b1;
      if (lv[i] != 9) seen_w = 1;
      else if (seen_w) e_err = 1'b1;
    end
    e_valid = 1'b0; e_static = 1'b0; e_q = 0; e_rnd = 0;
    for (int i = 0; i < NQ && !e_valid; i++)
      if (lv[i] == 9 && q_nonempty[i]) begin
        e_valid = 1'b1; e_static = 1'b1; e_q = i;
      end
    for (int k = 0; k < 8 && !e_valid; k++)
      for (int j = 1; j <= NQ && !e_valid; j++) begin
        int q, r;
        q = (m_last + j) % NQ;
        r = (m_rnd + k) % 8;
        if (q_nonempty[q] && lv[q] != 9 && ((ref_pat(lv[q]) >> r) & 1) == 1) begin
          e_valid = 1'b1; e_q = q; e_rnd = r;
        end
      end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; grant_ack = 1'b0; q_nonempty = '0; q_level = '0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    m_rnd = 0; m_last = NQ - 1;
  endtask

  task automatic step_compare(input string tag);
    #1;
    model();
    chk(gnt_valid == e_valid, {tag, " valid"}, int'(gnt_valid), int'(e_valid));
    if (e_valid) begin
      chk(int'(gnt_queue) == e_q, {tag, " queue"}, int'(gnt_queue), e_q);
      chk(gnt_static == e_static, {tag, " static"}, int'(gnt_static), int'(e_static));
    end
    chk(cfg_err == e_err, {tag, " cfg_err"}, int'(cfg_err), int'(e_err));
    if (grant_ack && e_valid && !e_static) begin
      m_rnd = (e_rnd + 1) % 8; m_last = e_q;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    int c0, c1;
    do_reset();

    // R1 R12: idle after reset, then first grant is queue 0 in round 0
    #1;
    chk(!gnt_valid, "R1 idle after reset", int'(gnt_valid), 0);
    chk(!cfg_err, "R12 no error at reset", int'(cfg_err), 0);
    q_level = {4'd8, 4'd8, 4'd0, 4'd1};
    q_nonempty = 4'b1111;
    #1;
    chk(int'(gnt_queue) == 0, "R12 first grant queue 0", int'(gnt_queue), 0);

    // R1 R3: only level-0 queues non-empty
    q_level = {4'd0, 4'd0, 4'd0, 4'd0};
    #1;
    chk(!gnt_valid, "R3 level 0 never granted", int'(gnt_valid), 0);

    // R2 R6 R7: share of level 1 vs level 8 over 16 accepted grants
    do_reset();
    q_level = {4'd0, 4'd0, 4'd8, 4'd1};
    q_nonempty = 4'b0011; grant_ack = 1'b1;
    c0 = 0; c1 = 0;
    for (int n = 0; n < 16; n++) begin
      #1;
      if (gnt_queue == 0) c0++; else if (gnt_queue == 1) c1++;
      @(negedge clk);
    end
    chk(c0 == 2, "R2 level1 share", c0, 2);
    chk(c1 == 14, "R7 level8 share", c1, 14);

    // R4 R5: strict queues beat weighted, lowest wins, state unchanged
    do_reset();
    q_level = {4'd8, 4'd8, 4'd9, 4'd9};
    q_nonempty = 4'b1110; grant_ack = 1'b1;
    #1;
    chk(int'(gnt_queue) == 1 && gnt_static, "R4 strict wins", int'(gnt_queue), 1);
    @(negedge clk);
    q_nonempty = 4'b1100;
    #1;
    chk(int'(gnt_queue) == 2 && !gnt_static, "R5 pointer unchanged", int'(gnt_queue), 2);

    // R8: out-of-range level
    q_level = {4'd0, 4'd0, 4'd0, 4'd12};
    q_nonempty = 4'b0001;
    #1;
    chk(cfg_err, "R8 error on level 12", int'(cfg_err), 1);
    chk(gnt_valid && gnt_queue == 0, "R8 pattern FF", int'(gnt_queue), 0);

    // R9: strict after weighted
    q_level = {4'd0, 4'd9, 4'd3, 4'd9};
    #1;
    chk(cfg_err, "R9 non-contiguous strict", int'(cfg_err), 1);
    q_level = {4'd3, 4'd3, 4'd9, 4'd9};
    #1;
    chk(!cfg_err, "R9 contiguous strict ok", int'(cfg_err), 0);

    // R11: hold without ack
    do_reset();
    q_level = {4'd5, 4'd3, 4'd7, 4'd2};
    q_nonempty = 4'b1111; grant_ack = 1'b0;
    #1; c0 = int'(gnt_queue);
    repeat (3) @(negedge clk);
    #1;
    chk(int'(gnt_queue) == c0, "R11 hold without ack", int'(gnt_queue), c0);

    // R10 R2 R6 R7: sweep with levels and occupancy changing every cycle
    do_reset();
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 6000; n++) begin
      for (int i = 0; i < NQ; i++) begin
        int l;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        l = int'(lfsr[7:0]) % 11;
        if (n % 3 == 0) l = int'(lfsr[9:8]) + 6;
        q_level[4*i +: 4] = (l == 10) ? 4'(10 + int'(lfsr[12:11])) : 4'(l);
      end
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      q_nonempty = lfsr[3:0];
      grant_ack = lfsr[5] | lfsr[6];
      step_compare("R10 sweep");
      @(negedge clk);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule